// File: doc/BRIEF.md
# Arithmetic Right Shifter with Inexact-Carry Flag

This block shifts a signed operand to the right, filling vacated high bits with copies of its sign, in either a 32-bit or a 64-bit width. Along with the shifted value it returns a carry flag. The carry is set when a negative operand loses at least one 1 bit during the shift, which tells the consumer that the result was rounded toward minus infinity. A shift of zero and a shift that is out of range are both handled as defined cases.

The shift count comes from a 7-bit amount field. In 32-bit width the low six bits count, and bit 5 is the out-of-range indicator. In 64-bit width all seven bits count, and bit 6 is the out-of-range indicator. An out-of-range count fills the whole result with the sign bit and does not wrap. Results from the 32-bit width are sign-extended to the full output width. The datapath has one register stage. A request that is presented with `in_valid` is captured on the next clock edge, and the output holds until the next request arrives.

Top module: `sra_unit`

## Requirements
- R1: In 32-bit width (`mode_wide`=0) with amount bit 5 clear, `result` is operand[31:0] shifted right arithmetically by amount[4:0], then sign-extended from bit 31 to 64 bits. Amount bit 6 has no effect in this width.
- R2: In 64-bit width (`mode_wide`=1) with amount bit 6 clear, `result` is the 64-bit operand shifted right arithmetically by amount[5:0]. A count of 32 to 63 is in range in this width.
- R3: For an in-range shift, `carry` is 1 only when the operand's sign bit (bit 31 or bit 63, depending on width) is 1 and at least one 1 bit was shifted out. In every other in-range case it is 0.
- R4: A shift amount of zero returns the operand unchanged (sign-extended from bit 31 in 32-bit width) and clears `carry`.
- R5: When the out-of-range bit is set (bit 5 in 32-bit width, bit 6 in 64-bit width), every bit of `result` equals the operand's sign bit.
- R6: In the out-of-range case, `carry` is 1 only when the operand is negative and has a 1 bit below its sign bit.
- R7: `out_valid` is 1 in the cycle after a cycle with `in_valid`=1 and 0 otherwise. `result` and `carry` change only after an `in_valid` cycle and hold their values otherwise.
- R8: While reset is asserted, `out_valid`, `result` and `carry` are 0.
- R9: In 32-bit width, operand bits 63:32 have no effect on `result` or `carry`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| in_valid | input | 1 | Request strobe; the inputs are captured on the next rising edge |
| mode_wide | input | 1 | 0 selects 32-bit width, 1 selects 64-bit width |
| operand | input | 64 | Value to be shifted |
| amount | input | 7 | Shift count; the top bit used in the selected width marks an out-of-range count |
| out_valid | output | 1 | High for one cycle after each captured request |
| result | output | 64 | Registered shifted value |
| carry | output | 1 | Registered inexact flag for negative operands |

## Verification
The assertions check the following properties on every cycle:
- the one-cycle handshake and the holding of the output between requests;
- that a non-negative operand never produces `carry`;
- sign extension of every 32-bit result;
- that a zero count in 64-bit width passes the operand through unchanged;
- the full sign fill and its carry rule for an out-of-range count in 64-bit width.

The exact shifted values, the carry for negative operands that do or do not lose a 1 bit, the handling of amount bit 6 in 32-bit width, and the independence from the upper operand half can only be shown by the bench. It applies hand-computed vectors and then sweeps every count in both widths over several operands.

// File: rtl/sra_pkg.sv
package sra_pkg;
  localparam int SRA_XLEN = 64;

  typedef enum logic {
    SRA_W32 = 1'b0,
    SRA_W64 = 1'b1
  } sra_width_e;
endpackage

// File: rtl/sra_rst_sync.sv
module sra_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/sra_lane.sv
// One shift lane of width W. The count is SW+1 bits wide, and its top bit
// marks an out-of-range shift.
module sra_lane #(
  parameter int W = 32
) (
  input  logic [W-1:0]          x,
  input  logic [$clog2(W):0]    amt,
  output logic [W-1:0]          res,
  output logic                  ca
);
  localparam int SW = $clog2(W);

  logic          sign;
  logic          oor;
  logic [SW-1:0] sh;
  logic [W-1:0]  lost_mask;

  always_comb begin
    sign = x[W-1];
    oor  = amt[SW];
    sh   = amt[SW-1:0];
    if (oor) begin
      // every bit below the sign is discarded
      lost_mask = {1'b0, {(W-1){1'b1}}};
      res       = {W{sign}};
    end else begin
      lost_mask = ~({W{1'b1}} << sh);
      res       = $signed(x) >>> sh;
    end
    ca = sign & (|(x & lost_mask));
  end
endmodule

// File: rtl/sra_out_reg.sv
module sra_out_reg #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d_res,
  input  logic         d_ca,
  output logic [W-1:0] q_res,
  output logic         q_ca,
  output logic         q_valid
);
  logic [W-1:0] res_nxt;
  logic         ca_nxt;

  always_comb begin
    res_nxt = q_res;
    ca_nxt  = q_ca;
    if (en) begin
      res_nxt = d_res;
      ca_nxt  = d_ca;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_res   <= '0;
      q_ca    <= 1'b0;
      q_valid <= 1'b0;
    end else begin
      q_res   <= res_nxt;
      q_ca    <= ca_nxt;
      q_valid <= en;
    end
  end
endmodule

// File: rtl/sra_unit.sv
module sra_unit #(
  parameter int DATA_W = sra_pkg::SRA_XLEN
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic                         mode_wide,
  input  logic [DATA_W-1:0]            operand,
  input  logic [$clog2(DATA_W):0]      amount,
  output logic                         out_valid,
  output logic [DATA_W-1:0]            result,
  output logic                         carry
);
  localparam int HALF_W  = DATA_W / 2;
  localparam int N_LANES = 2;

  logic              rst_sync_n;
  logic [DATA_W-1:0] lane_res [N_LANES];
  logic              lane_ca  [N_LANES];
  logic [DATA_W-1:0] sel_res;
  logic              sel_ca;
  sra_pkg::sra_width_e width_sel;

  sra_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // lane 0 covers half width, lane 1 covers full width
  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    localparam int LW = (g == 0) ? HALF_W : DATA_W;
    logic [LW-1:0] r;
    logic          c;

    sra_lane #(.W(LW)) u_lane (
      .x   (operand[LW-1:0]),
      .amt (amount[$clog2(LW):0]),
      .res (r),
      .ca  (c)
    );

    assign lane_res[g] = DATA_W'($signed(r));
    assign lane_ca[g]  = c;
  end

  always_comb begin
    width_sel = sra_pkg::sra_width_e'(mode_wide);
    if (width_sel == sra_pkg::SRA_W64) begin
      sel_res = lane_res[1];
      sel_ca  = lane_ca[1];
    end else begin
      sel_res = lane_res[0];
      sel_ca  = lane_ca[0];
    end
  end

  sra_out_reg #(.W(DATA_W)) u_oreg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en      (in_valid),
    .d_res   (sel_res),
    .d_ca    (sel_ca),
    .q_res   (result),
    .q_ca    (carry),
    .q_valid (out_valid)
  );
endmodule

// File: rtl/sra_unit_chk.sv
module sra_unit_chk #(
  parameter int DATA_W = 64
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    mode_wide,
  input logic [DATA_W-1:0]       operand,
  input logic [$clog2(DATA_W):0] amount,
  input logic                    out_valid,
  input logic [DATA_W-1:0]       result,
  input logic                    carry
);
  localparam int HALF_W = DATA_W / 2;
  localparam int AMT_W  = $clog2(DATA_W) + 1;

  logic in_sign;
  assign in_sign = mode_wide ? operand[DATA_W-1] : operand[HALF_W-1];

  // R7: handshake latency
  p_valid_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R7: output holds without a request
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(carry)));
  // R3: a non-negative operand never raises carry
  p_nonneg_ca_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sign) |=> !carry);
  // R1: 32-bit results are sign-extended
  p_sext_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode_wide) |=> (result[DATA_W-1:HALF_W] == {HALF_W{result[HALF_W-1]}}));
  // R4: zero count in 64-bit width passes the operand through
  p_zero_amt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_wide && amount == '0) |=> (result == $past(operand) && !carry));
  // R5: out-of-range count fills with the sign
  p_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_wide && amount[AMT_W-1]) |=> (result == {DATA_W{$past(operand[DATA_W-1])}}));
  // R6: out-of-range carry
  p_oor_ca_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_wide && amount[AMT_W-1]) |=>
      (carry == ($past(operand[DATA_W-1]) && (|$past(operand[DATA_W-2:0])))));
endmodule

bind sra_unit sra_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .mode_wide (mode_wide),
  .operand   (operand),
  .amount    (amount),
  .out_valid (out_valid),
  .result    (result),
  .carry     (carry)
);

// File: tb/sim_sra_unit.sv
module sim_sra_unit;
  localparam int NV = 15;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        mode_wide;
  logic [63:0] operand;
  logic [6:0]  amount;
  logic        out_valid;
  logic [63:0] result;
  logic        carry;

  int n_chk;
  int n_bad;
  bit done;

  // {mode, amount[6:0], operand[63:0], expected result[63:0], expected carry}
  localparam logic [136:0] TBL [NV] = '{
    {1'b0, 7'h04, 64'h0000_0000_8000_00F0, 64'hFFFF_FFFF_F800_000F, 1'b0}, // R1
    {1'b0, 7'h04, 64'h0000_0000_8000_00F8, 64'hFFFF_FFFF_F800_000F, 1'b1}, // R3
    {1'b0, 7'h08, 64'hFFFF_FFFF_7FFF_FF00, 64'h0000_0000_007F_FFFF, 1'b0}, // R9
    {1'b0, 7'h20, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0}, // R5
    {1'b0, 7'h21, 64'h0000_0000_8000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1}, // R6
    {1'b0, 7'h43, 64'h0000_0000_F000_0000, 64'hFFFF_FFFF_FE00_0000, 1'b0}, // R1
    {1'b0, 7'h00, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_9ABC_DEF0, 1'b0}, // R4
    {1'b1, 7'h00, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001, 1'b0}, // R4
    {1'b1, 7'h24, 64'hF000_0000_0000_0000, 64'hFFFF_FFFF_FF00_0000, 1'b0}, // R2
    {1'b1, 7'h24, 64'hF000_0000_8000_0000, 64'hFFFF_FFFF_FF00_0000, 1'b1}, // R3
    {1'b1, 7'h3F, 64'h4000_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b0}, // R2
    {1'b1, 7'h40, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0}, // R6
    {1'b1, 7'h7F, 64'h8000_0000_0000_0100, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1}, // R6
    {1'b1, 7'h40, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 1'b0}, // R5
    {1'b1, 7'h20, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001, 1'b0}  // R2
  };

  sra_unit u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode_wide (mode_wide),
    .operand   (operand),
    .amount    (amount),
    .out_valid (out_valid),
    .result    (result),
    .carry     (carry)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // model written from the requirements
  function automatic logic [64:0] model(input logic m, input logic [6:0] a, input logic [63:0] op);
    logic [63:0] r;
    logic        c;
    if (m) begin
      if (a[6]) begin
        r = {64{op[63]}};
        c = op[63] && (|op[62:0]);
      end else begin
        r = $signed(op) >>> a[5:0];
        c = op[63] && (|(op & ~(64'hFFFF_FFFF_FFFF_FFFF << a[5:0])));
      end
    end else begin
      logic [31:0] x;
      logic [31:0] r32;
      x = op[31:0];
      if (a[5]) begin
        r32 = {32{x[31]}};
        c   = x[31] && (|x[30:0]);
      end else begin
        r32 = $signed(x) >>> a[4:0];
        c   = x[31] && (|(x & ~(32'hFFFF_FFFF << a[4:0])));
      end
      r = {{32{r32[31]}}, r32};
    end
    return {r, c};
  endfunction

  task automatic apply(input logic m, input logic [6:0] a, input logic [63:0] op);
    @(negedge clk);
    mode_wide = m;
    amount    = a;
    operand   = op;
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid  = 1'b0;
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; mode_wide = 1'b0; operand = '0; amount = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 out_valid", {63'b0, out_valid}, 64'd0);
    chk("R8 result", result, 64'd0);
    chk("R8 carry", {63'b0, carry}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [136:0] e;
      e = TBL[i];
      apply(e[136], e[135:129], e[128:65]);
      chk("R7 out_valid", {63'b0, out_valid}, 64'd1);
      chk("R1/R2/R4/R5 result", result, e[64:1]);
      chk("R3/R6 carry", {63'b0, carry}, {63'b0, e[0]});
    end

    // R7: hold while idle, operand changes are ignored
    apply(1'b1, 7'h24, 64'hF000_0000_8000_0000);
    @(negedge clk);
    operand = 64'h0000_0000_0000_0000; amount = 7'h01; mode_wide = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 idle out_valid", {63'b0, out_valid}, 64'd0);
    chk("R7 held result", result, 64'hFFFF_FFFF_FF00_0000);
    chk("R7 held carry", {63'b0, carry}, 64'd1);

    // R9: upper half ignored in 32-bit width
    apply(1'b0, 7'h05, 64'h0000_0000_8000_0011);
    chk("R9 base", result, 64'hFFFF_FFFF_FC00_0000);
    apply(1'b0, 7'h05, 64'hDEAD_BEEF_8000_0011);
    chk("R9 result", result, 64'hFFFF_FFFF_FC00_0000);
    chk("R9 carry", {63'b0, carry}, 64'd1);

    // R1 R2 R3 R5 R6: sweep of every count in both widths
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 128; a++) begin
        for (int k = 0; k < 3; k++) begin
          logic [63:0] op;
          logic [64:0] exp;
          op  = (k == 0) ? 64'hA5C3_0F81_9E24_7B61 :
                (k == 1) ? 64'h3C5A_96E1_7F00_0080 : 64'h8000_0001_8000_0000;
          exp = model(m[0], a[6:0], op);
          apply(m[0], a[6:0], op);
          chk("R1/R2 sweep result", result, exp[64:1]);
          chk("R3/R6 sweep carry", {63'b0, carry}, {63'b0, exp[0]});
        end
      end
    end

    // R8: reset asserted mid-run clears the outputs
    apply(1'b1, 7'h01, 64'hFFFF_FFFF_FFFF_FFFF);
    rst_n = 1'b0;
    #1;
    chk("R8 mid result", result, 64'd0);
    chk("R8 mid carry", {63'b0, carry}, 64'd0);
    finish_run();
  end
endmodule